// File: doc/BRIEF.md
# I2C Slave Configuration Register Bank

This block lets an external I2C master read and write a bank of 128 eight-bit configuration registers. The SCL and SDA pins are sampled by the system clock, which must be much faster than SCL. The block answers on SDA only through a low-drive enable, so SDA stays open-drain. Access works like a small serial EEPROM. The master sends a fixed write device byte and a one-byte register pointer, then any number of data bytes. It reads by sending a fixed read device byte, either directly from the current pointer or after a repeated START that follows a pointer-setting write.

The two device bytes are complete 8-bit values. 0xBE selects a write and 0xBF selects a read. The block does not split them into an address and a direction bit. Any other device byte gets no acknowledge, and the block stays silent until the next START.

Bit 0 of register 1 is a run control bit, and it is brought out on `run_o`. A write can set it, but only reset clears it. This lets the master load every setting before it starts the surrounding logic.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The bank holds 128 registers of 8 bits. The register pointer is 7 bits wide and is taken from bits 6..0 of the address byte. Bit 7 of the address byte is ignored.
- R2: The block acknowledges device byte 0xBE (write) and 0xBF (read). Any other device byte is not acknowledged. The rest of that transaction then changes no register and gets no acknowledge.
- R3: A write transaction is the device byte 0xBE, then the address byte, then one or more data bytes. The block acknowledges each of these bytes, and each data byte is stored at the current pointer.
- R4: A read that starts with 0xBF, with no address byte before it, returns data starting at the current pointer.
- R5: A random read is 0xBE, then the address byte, then a repeated START, then 0xBF. It returns the addressed register's data, most significant bit first.
- R6: The pointer increments by one after each data byte that is read or written, and it wraps from 127 to 0.
- R7: During a read, a master NACK ends the transfer. SDA is released and stays released until the next START.
- R8: A STOP or a START at any point returns the block to its idle or device-byte state. Data bytes that were already complete stay stored, and a partly received byte is discarded.
- R9: Register 1 bit 0 is the run bit and is shown on `run_o`. Writing 1 sets it. A later write of 0 leaves it at 1. The other bits of register 1 can be written normally.
- R10: After reset, all registers read 0, `run_o` is 0 and `sda_oe_o` is 0.
- R11: `sda_oe_o` only turns on while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| run_o | output | 1 | Sticky run bit, register 1 bit 0 |

## Verification
The hardest case to reach is a STOP that cuts a data byte off partway through. The bench must show that the bytes completed before it are kept and the half-shifted byte is dropped. A custom bit-level master task sends four data bits and then issues a STOP from the low phase of SCL. The bench then reads back both neighbouring registers. The bench also sends a foreign device byte followed by what looks like an address and data. It then reads the target register back to prove the ignored transaction wrote nothing. Finally, it chains a write across the 127 to 0 wrap with a read across the same boundary.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_ACK,
    ST_RACK,
    ST_SKIP
  } st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev_q;

  assign raw = {sda_i, scl_i};

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], raw[l]};
    end
    assign synced[l] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= synced;
  end

  assign scl_o      = synced[0];
  assign sda_o      = synced[1];
  assign scl_rise_o = synced[0] & ~prev_q[0];
  assign scl_fall_o = ~synced[0] & prev_q[0];
  // SDA edges with SCL held high on both samples
  assign start_o    = synced[0] & prev_q[0] & prev_q[1] & ~synced[1];
  assign stop_o     = synced[0] & prev_q[0] & ~prev_q[1] & synced[1];
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int DEPTH      = 128,
  parameter int DATA_W     = 8,
  parameter int STICKY_REG = 1,
  parameter int STICKY_BIT = 0,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sticky_o
);
  localparam logic [DATA_W-1:0] STICKY_MASK = DATA_W'(1) << STICKY_BIT;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && (addr_i == ADDR_W'(g));
    if (g == STICKY_REG) begin : g_sticky
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  mem_q[g] <= '0;
        else if (hit) mem_q[g] <= wr_data_i | (mem_q[g] & STICKY_MASK);
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  mem_q[g] <= '0;
        else if (hit) mem_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[addr_i];
  assign sticky_o  = mem_q[STICKY_REG][STICKY_BIT];
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_rf_pkg::*;
#(
  parameter int              ADDR_W = 7,
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] WR_DEV = 8'hBE,
  parameter logic [DATA_W-1:0] RD_DEV = 8'hBF,
  localparam int             CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sda_oe_o,
  output st_e               state_o
);
  st_e               st_q, nxt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              oe_q;
  logic              byte_end;

  assign byte_end  = scl_fall_i && (cnt_q == CNT_W'(DATA_W));
  assign wr_en_o   = (st_q == ST_WDATA) && byte_end && !start_i && !stop_i;
  assign wr_data_o = sh_q;
  assign ptr_o     = ptr_q;
  assign sda_oe_o  = oe_q;
  assign state_o   = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      nxt_q <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      ptr_q <= '0;
      oe_q  <= 1'b0;
    end else if (start_i) begin
      st_q  <= ST_DEV;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[DATA_W-2:0], sda_i};
            cnt_q <= cnt_q + CNT_W'(1);
          end else if (byte_end) begin
            cnt_q <= '0;
            if (st_q == ST_DEV) begin
              if (sh_q == WR_DEV) begin
                oe_q <= 1'b1; st_q <= ST_ACK; nxt_q <= ST_ADDR;
              end else if (sh_q == RD_DEV) begin
                oe_q <= 1'b1; st_q <= ST_ACK; nxt_q <= ST_RDATA;
              end else begin
                st_q <= ST_SKIP;
              end
            end else if (st_q == ST_ADDR) begin
              ptr_q <= sh_q[ADDR_W-1:0];
              oe_q  <= 1'b1; st_q <= ST_ACK; nxt_q <= ST_WDATA;
            end else begin
              ptr_q <= ptr_q + ADDR_W'(1);
              oe_q  <= 1'b1; st_q <= ST_ACK; nxt_q <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            if (nxt_q == ST_RDATA) begin
              sh_q  <= rd_data_i;
              oe_q  <= ~rd_data_i[DATA_W-1];
              ptr_q <= ptr_q + ADDR_W'(1);
              cnt_q <= '0;
            end else begin
              oe_q <= 1'b0;
            end
            st_q <= nxt_q;
          end
        end
        ST_RDATA: begin
          if (scl_rise_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end else if (byte_end) begin
            oe_q  <= 1'b0;
            cnt_q <= '0;
            st_q  <= ST_RACK;
          end else if (scl_fall_i) begin
            sh_q <= {sh_q[DATA_W-2:0], 1'b0};
            oe_q <= ~sh_q[DATA_W-2];
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            if (sda_i) st_q <= ST_SKIP;  // master NACK
          end else if (scl_fall_i) begin
            sh_q  <= rd_data_i;
            oe_q  <= ~rd_data_i[DATA_W-1];
            ptr_q <= ptr_q + ADDR_W'(1);
            st_q  <= ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
  parameter int              REG_COUNT   = 128,
  parameter int              DATA_W      = 8,
  parameter int              SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] WR_DEV    = 8'hBE,
  parameter logic [DATA_W-1:0] RD_DEV    = 8'hBF,
  parameter int              RUN_REG     = 1,
  parameter int              RUN_BIT     = 0,
  localparam int             ADDR_W      = $clog2(REG_COUNT)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic run_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] wr_data, rd_data;
  i2c_rf_pkg::st_e   state;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_slave_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_DEV(WR_DEV), .RD_DEV(RD_DEV)
  ) i_ctrl (
    .clk_i, .rst_ni,
    .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .rd_data_i(rd_data), .ptr_o(ptr), .wr_en_o(wr_en),
    .wr_data_o(wr_data), .sda_oe_o(sda_oe_o), .state_o(state)
  );

  i2c_reg_bank #(
    .DEPTH(REG_COUNT), .DATA_W(DATA_W), .STICKY_REG(RUN_REG), .STICKY_BIT(RUN_BIT)
  ) i_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .addr_i(ptr),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .sticky_o(run_o)
  );
endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker #(
  parameter int ADDR_W  = 7,
  parameter int RUN_REG = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              wr_en,
  input logic              wr_bit0,
  input logic [ADDR_W-1:0] ptr,
  input i2c_rf_pkg::st_e   state,
  input logic              sda_oe_o,
  input logic              run_o
);
  import i2c_rf_pkg::*;

  p_oe_rise_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  p_skip_silent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SKIP) |-> !sda_oe_o);

  p_ptr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (ptr == ADDR_W'($past(ptr) + ADDR_W'(1))));

  p_run_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> run_o);

  p_run_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(wr_en && (ptr == ADDR_W'(RUN_REG)) && wr_bit0));

  p_stop_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state == ST_IDLE) && !sda_oe_o);

  p_start_dev_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state == ST_DEV) && !sda_oe_o);
endmodule

bind i2c_regfile_slave i2c_rf_checker #(.ADDR_W(ADDR_W), .RUN_REG(RUN_REG)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s),
  .start_det(start_det), .stop_det(stop_det),
  .wr_en(wr_en), .wr_bit0(wr_data[0]), .ptr(ptr), .state(state),
  .sda_oe_o(sda_oe_o), .run_o(run_o)
);

// File: tb/test_i2c_regfile_slave.sv
module test_i2c_regfile_slave;
  localparam int Q = 8;  // quarter SCL period in clk cycles

  logic clk = 0, rst_n = 0, scl = 1, msda = 1;
  logic sda_oe, run;
  wire  sda_bus = msda & ~sda_oe;

  always #4 clk = ~clk;

  i2c_regfile_slave i_i2c_regfile_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .run_o(run)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] mdl [128];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(g == e, t, g, e);
    end
  end

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    msda = 1; wq(Q); scl = 1; wq(Q); msda = 0; wq(Q); scl = 0; wq(Q);
  endtask
  task automatic bus_stop;
    msda = 0; wq(Q); scl = 1; wq(Q); msda = 1; wq(2*Q);
  endtask
  task automatic send_bit(input logic b);
    msda = b; wq(Q); scl = 1; wq(2*Q); scl = 0; wq(Q);
  endtask
  task automatic recv_bit(output logic b);
    msda = 1; wq(Q); scl = 1; wq(Q); b = sda_bus; wq(Q); scl = 0; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, input bit exp_ack, input string req);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    chk((~a) == exp_ack, req, ~a, exp_ack);
  endtask

  task automatic rd_byte(input logic [7:0] e, input bit last, input string req);
    logic [7:0] v;
    logic b;
    exp_q.push_back(e); tag_q.push_back(req);
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    got_q.push_back(v);
    send_bit(last);
  endtask

  function automatic void mdl_wr(input int a, input logic [7:0] d);
    if (a == 1) mdl[a] = d | (mdl[a] & 8'h01);
    else        mdl[a] = d;
  endfunction

  task automatic wr_seq(input logic [7:0] addr, input logic [7:0] d [], input string req);
    int p;
    p = addr[6:0];
    bus_start;
    wr_byte(8'hBE, 1, "R2 write device ack");
    wr_byte(addr, 1, "R3 address ack");
    foreach (d[i]) begin
      wr_byte(d[i], 1, req);
      mdl_wr(p, d[i]);
      p = (p + 1) % 128;
    end
    bus_stop;
  endtask

  task automatic rand_read(input logic [7:0] addr, input int n, input string req);
    int p;
    p = addr[6:0];
    bus_start;
    wr_byte(8'hBE, 1, "R5 device ack");
    wr_byte(addr, 1, "R5 address ack");
    bus_start;
    wr_byte(8'hBF, 1, "R5 read device ack");
    for (int i = 0; i < n; i++) begin
      rd_byte(mdl[p], i == n - 1, req);
      p = (p + 1) % 128;
    end
    bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    wq(5); rst_n = 1; wq(5);

    // R10 reset state
    chk(sda_oe == 0, "R10 sda released", sda_oe, 0);
    chk(run == 0, "R10 run low", run, 0);
    rand_read(8'h05, 1, "R10 reset register value");

    // R3 burst write, R5/R6 random sequential read
    wr_seq(8'h10, '{8'hA5, 8'h3C, 8'h81}, "R3 data ack");
    rand_read(8'h10, 3, "R5 R6 sequential read");

    // R4 current-pointer read
    bus_start;
    wr_byte(8'hBE, 1, "R2 write device ack");
    wr_byte(8'h11, 1, "R4 address ack");
    bus_stop;
    bus_start;
    wr_byte(8'hBF, 1, "R2 read device ack");
    rd_byte(mdl[8'h11], 0, "R4 current read first");
    rd_byte(mdl[8'h12], 1, "R4 current read second");
    bus_stop;

    // R7 NACK releases SDA
    chk(sda_oe == 0, "R7 sda released after nack", sda_oe, 0);

    // R6 wrap 127 -> 0
    wr_seq(8'h7F, '{8'h5E, 8'hC7}, "R6 wrap write ack");
    rand_read(8'h7F, 2, "R6 wrap read");

    // R2 foreign device byte ignored
    bus_start;
    wr_byte(8'hA0, 0, "R2 foreign device nack");
    wr_byte(8'h10, 0, "R2 no ack after foreign");
    wr_byte(8'hFF, 0, "R2 no ack data after foreign");
    bus_stop;
    bus_start;
    wr_byte(8'hBC, 0, "R2 near-miss device nack");
    bus_stop;
    rand_read(8'h10, 1, "R2 register untouched");

    // R1 address bit 7 ignored
    wr_seq(8'hA0, '{8'h77}, "R1 data ack");
    rand_read(8'h20, 1, "R1 alias read");

    // R8 STOP mid-byte
    bus_start;
    wr_byte(8'hBE, 1, "R8 device ack");
    wr_byte(8'h30, 1, "R8 address ack");
    wr_byte(8'h9A, 1, "R8 data ack");
    mdl_wr(8'h30, 8'h9A);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop;
    chk(sda_oe == 0, "R8 released after stop", sda_oe, 0);
    rand_read(8'h30, 2, "R8 committed kept partial dropped");

    // R8 START mid-byte aborts to device phase
    bus_start;
    wr_byte(8'hBE, 1, "R8 device ack");
    wr_byte(8'h31, 1, "R8 address ack");
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    bus_start;
    wr_byte(8'hBF, 1, "R8 restart read ack");
    rd_byte(mdl[8'h31], 1, "R8 restart read value");
    bus_stop;

    // R9 sticky run bit
    wr_seq(8'h01, '{8'h06}, "R9 data ack");
    wq(4);
    chk(run == 0, "R9 run still low", run, 0);
    wr_seq(8'h01, '{8'h01}, "R9 data ack");
    wq(4);
    chk(run == 1, "R9 run set", run, 1);
    wr_seq(8'h01, '{8'h00}, "R9 clear attempt ack");
    wq(4);
    chk(run == 1, "R9 run sticky", run, 1);
    rand_read(8'h01, 1, "R9 register readback");

    wq(20);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule